// File: doc/BRIEF.md
# I/O Rail Deep Power-Down Sequencer

This block moves one I/O pad rail at a time into or out of deep power-down. A command gives a rail index and a direction. The block checks the index and opens a sample window for the pads. That window has a hold-time count worth at least 200 ns at the bus clock. The block then issues a request word on one of two request outputs and watches that rail's bit on the matching status input until it reaches the expected level. The run ends with a one-cycle `done` pulse on success or a one-cycle `error` pulse on rejection or timeout. The sample window closes in both cases.

Rail indices 0 to 31 belong to the low request/status pair and 32 to 63 to the high pair. Within either request word, bits 31:30 hold a command code. The rail positions 30 and 31 of each pair therefore cannot be addressed.

The sequencer has six states:
- `ST_IDLE` takes a command. A valid index goes to `ST_PREP` and an invalid one goes to `ST_FAIL`.
- `ST_PREP` always goes to `ST_ISSUE`.
- `ST_ISSUE` writes the request word and goes to `ST_POLL`.
- `ST_POLL` goes to `ST_DONE` on a status match, to `ST_FAIL` when the poll limit expires, and otherwise stays in `ST_POLL`.
- `ST_DONE` and `ST_FAIL` each last one cycle and return to `ST_IDLE`.

Top module: `iorail_dpd_ctrl`

## Requirements
- R1: After reset, both request words, `sample_en`, `sample_tmr`, `busy`, `done` and `error` are all zero.
- R2: A rail index r in 0..31 selects the low pair with bit position r; an index in 32..63 selects the high pair with bit position r-32; the request word of the other pair does not change.
- R3: An index of 64 or more, or one whose bit position within its pair is 30 or 31 (30, 31, 62, 63), is rejected: `error` pulses in the first cycle after the command, and neither request word nor `sample_en` changes.
- R4: While the request is out, the selected word is {code, selector}: code in bits 31:30 is 01 for leaving power-down (`cmd_exit`=1) and 10 for entering it (`cmd_exit`=0), and bits 29:0 are one-hot on the rail's bit position. Code 11 never appears.
- R5: `sample_en` rises in the first cycle after an accepted command, stays high until the run ends, and is low in the `done`/`error` cycle. `sample_tmr` holds ceil(SAMPLE_MIN_PS / CLK_PERIOD_PS) from that first cycle on; this is 20 at the default 10 ns period.
- R6: A leave command completes when the rail's status bit reads 0, and an enter command completes when it reads 1. If the status already matches, `done` pulses in the fourth cycle after the command.
- R7: If the status bit never matches, `error` pulses after TIMEOUT_CYCLES poll cycles. That is the (3+TIMEOUT_CYCLES)-th cycle after the command.
- R8: When a run ends by success or timeout, bits 31:30 of the selected word return to 00 and its selector bits are kept.
- R9: `cmd_valid` is ignored while `busy` is high.
- R10: `done` and `error` are never high together and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_rail | input | RAIL_W | Rail index |
| cmd_exit | input | 1 | 1 = leave power-down (rail on), 0 = enter it (rail off) |
| status_lo | input | 32 | Status bits of rails 0..31 |
| status_hi | input | 32 | Status bits of rails 32..63 |
| req_lo | output | 32 | Request word, low pair |
| req_hi | output | 32 | Request word, high pair |
| sample_en | output | 1 | Pad sample window enable |
| sample_tmr | output | TMR_W | Sample hold time in bus clock cycles |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle rejection or timeout pulse |

## Verification
Some properties are checked on every cycle: `done` and `error` are exclusive single-cycle pulses, no request word ever carries code 11, and at most one pair holds a non-idle code. They also check that the sample window closes at the end of every run and that the hold count stays steady while the window is open. Other behaviour is only visible in the bench scenarios:
- which pair and bit an index selects, and which indices are rejected;
- the status level that ends each direction;
- the exact cycle of a timeout;
- the code returning to idle with the selector kept;
- a command that arrives while busy being dropped.

// File: rtl/iorail_dpd_pkg.sv
package iorail_dpd_pkg;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = 30;
    localparam int POS_W     = 5;
    localparam int NUM_RAILS = 64;

    localparam logic [1:0] CODE_IDLE  = 2'b00;
    localparam logic [1:0] CODE_EXIT  = 2'b01;
    localparam logic [1:0] CODE_ENTER = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ISSUE,
        ST_POLL,
        ST_DONE,
        ST_FAIL
    } dpd_state_e;
endpackage

// File: rtl/iorail_idx_decode.sv
module iorail_idx_decode
    import iorail_dpd_pkg::*;
#(
    parameter int RAIL_W = 7
) (
    input  logic [RAIL_W-1:0] rail,
    output logic              ok,
    output logic              hi_pair,
    output logic [POS_W-1:0]  pos,
    output logic [SEL_W-1:0]  mask
);
    logic in_range;

    always_comb begin
        in_range = (int'(rail) < NUM_RAILS);
        pos      = rail[POS_W-1:0];
        hi_pair  = rail[POS_W];
        ok       = in_range && (int'(pos) < SEL_W);
        mask     = ok ? (SEL_W'(1) << pos) : '0;
    end
endmodule

// File: rtl/iorail_poll_timer.sv
module iorail_poll_timer #(
    parameter int LIMIT = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/iorail_dpd_ctrl.sv
module iorail_dpd_ctrl
    import iorail_dpd_pkg::*;
#(
    parameter int RAIL_W         = 7,
    parameter int CLK_PERIOD_PS  = 10000,
    parameter int SAMPLE_MIN_PS  = 200000,
    parameter int TIMEOUT_CYCLES = 25_000_000,
    parameter int TMR_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [RAIL_W-1:0] cmd_rail,
    input  logic              cmd_exit,
    input  logic [31:0]       status_lo,
    input  logic [31:0]       status_hi,
    output logic [31:0]       req_lo,
    output logic [31:0]       req_hi,
    output logic              sample_en,
    output logic [TMR_W-1:0]  sample_tmr,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int               TMR_CYCLES = (SAMPLE_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam logic [TMR_W-1:0] TMR_VAL    = TMR_W'(TMR_CYCLES);

    dpd_state_e st_q, st_d;

    logic             dec_ok, dec_hi;
    logic [POS_W-1:0] dec_pos;
    logic [SEL_W-1:0] dec_mask;

    logic             op_hi, op_exit;
    logic [POS_W-1:0] op_pos;
    logic [SEL_W-1:0] op_mask;

    logic             accept, stat_bit, match, expired, poll_end;
    logic [31:0]      stat_word;

    iorail_idx_decode #(.RAIL_W(RAIL_W)) u_dec (
        .rail    (cmd_rail),
        .ok      (dec_ok),
        .hi_pair (dec_hi),
        .pos     (dec_pos),
        .mask    (dec_mask)
    );

    iorail_poll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (st_q != ST_POLL),
        .run     (st_q == ST_POLL && !match),
        .expired (expired)
    );

    assign accept    = (st_q == ST_IDLE) && cmd_valid && dec_ok;
    assign stat_word = op_hi ? status_hi : status_lo;
    assign stat_bit  = stat_word[op_pos];
    assign match     = (stat_bit == !op_exit);
    assign poll_end  = (st_q == ST_POLL) && (st_d != ST_POLL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_valid) st_d = dec_ok ? ST_PREP : ST_FAIL;
            ST_PREP:  st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_POLL;
            ST_POLL:  begin
                if (match)        st_d = ST_DONE;
                else if (expired) st_d = ST_FAIL;
            end
            ST_DONE:  st_d = ST_IDLE;
            ST_FAIL:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sample_en = (st_q == ST_PREP) || (st_q == ST_ISSUE) || (st_q == ST_POLL);
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        error     = (st_q == ST_FAIL);
    end

    // latched operation and sample hold count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_hi      <= 1'b0;
            op_exit    <= 1'b0;
            op_pos     <= '0;
            op_mask    <= '0;
            sample_tmr <= '0;
        end else if (accept) begin
            op_hi      <= dec_hi;
            op_exit    <= cmd_exit;
            op_pos     <= dec_pos;
            op_mask    <= dec_mask;
            sample_tmr <= TMR_VAL;
        end
    end

    // one request word per pair
    for (genvar g = 0; g < 2; g++) begin : g_pair
        logic [WORD_W-1:0] word_q;
        logic              mine;

        assign mine = (op_hi == 1'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (mine && st_q == ST_ISSUE) begin
                word_q <= {(op_exit ? CODE_EXIT : CODE_ENTER), op_mask};
            end else if (mine && poll_end) begin
                word_q[WORD_W-1:SEL_W] <= CODE_IDLE;
            end
        end
    end

    assign req_lo = g_pair[0].word_q;
    assign req_hi = g_pair[1].word_q;
endmodule

// File: rtl/iorail_dpd_ctrl_chk.sv
module iorail_dpd_ctrl_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      req_lo,
    input logic [31:0]      req_hi,
    input logic             sample_en,
    input logic [TMR_W-1:0] sample_tmr,
    input logic             busy,
    input logic             done,
    input logic             error
);
    AST_NO_DONE_AND_ERR: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error); // R10
    AST_NO_CODE_11: assert property (@(posedge clk) disable iff (!rst_n) (req_lo[31:30] != 2'b11) && (req_hi[31:30] != 2'b11)); // R4
    AST_ONE_PAIR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !((req_lo[31:30] != 2'b00) && (req_hi[31:30] != 2'b00))); // R2
    AST_SAMPLE_CLOSED_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> !sample_en); // R5
    AST_TMR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (sample_en && $past(sample_en)) |-> $stable(sample_tmr)); // R5
    AST_SAMPLE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sample_en |-> busy); // R5
endmodule

bind iorail_dpd_ctrl iorail_dpd_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_lo     (req_lo),
    .req_hi     (req_hi),
    .sample_en  (sample_en),
    .sample_tmr (sample_tmr),
    .busy       (busy),
    .done       (done),
    .error      (error)
);

// File: tb/iorail_dpd_ctrl_bench.sv
module iorail_dpd_ctrl_bench;
    localparam int RAIL_W = 7;
    localparam int TO     = 50;
    localparam int TMR_W  = 8;
    localparam int NVEC   = 12;

    // entry: {rail[6:0], exit, status_level, accept_ok}
    localparam logic [9:0] VEC [NVEC] = '{
        {7'd0,   1'b1, 1'b0, 1'b1},
        {7'd5,   1'b0, 1'b1, 1'b1},
        {7'd29,  1'b1, 1'b0, 1'b1},
        {7'd32,  1'b0, 1'b1, 1'b1},
        {7'd45,  1'b1, 1'b0, 1'b1},
        {7'd61,  1'b0, 1'b1, 1'b1},
        {7'd30,  1'b1, 1'b0, 1'b0},
        {7'd31,  1'b0, 1'b1, 1'b0},
        {7'd62,  1'b1, 1'b0, 1'b0},
        {7'd63,  1'b0, 1'b0, 1'b0},
        {7'd64,  1'b1, 1'b0, 1'b0},
        {7'd100, 1'b0, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [RAIL_W-1:0] cmd_rail = '0;
    logic              cmd_exit = 1'b0;
    logic [31:0]       status_lo = '0;
    logic [31:0]       status_hi = '0;
    logic [31:0]       req_lo, req_hi;
    logic              sample_en, busy, done, error;
    logic [TMR_W-1:0]  sample_tmr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_w [2];

    always #5 clk = ~clk;

    iorail_dpd_ctrl #(
        .RAIL_W(RAIL_W), .CLK_PERIOD_PS(10000), .SAMPLE_MIN_PS(200000),
        .TIMEOUT_CYCLES(TO), .TMR_W(TMR_W)
    ) u_iorail_dpd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rail(cmd_rail),
        .cmd_exit(cmd_exit), .status_lo(status_lo), .status_hi(status_hi),
        .req_lo(req_lo), .req_hi(req_hi), .sample_en(sample_en),
        .sample_tmr(sample_tmr), .busy(busy), .done(done), .error(error)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command and follow it to done/error. Samples at negedges.
    task automatic run_cmd(input logic [RAIL_W-1:0] rail, input logic ex,
                           output int k_end, output bit got_done, output bit got_err,
                           output logic [31:0] lo3, output logic [31:0] hi3,
                           output bit se_run, output logic [TMR_W-1:0] tmr1);
        k_end = 0; got_done = 0; got_err = 0; se_run = 1; lo3 = '0; hi3 = '0; tmr1 = '0;
        @(negedge clk);
        cmd_rail = rail; cmd_exit = ex; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k <= TO + 20; k++) begin
            if (k > 1) @(negedge clk);
            if (k == 1) tmr1 = sample_tmr;
            if (k == 3) begin lo3 = req_lo; hi3 = req_hi; end
            if (done || error) begin
                k_end = k; got_done = done; got_err = error;
                break;
            end
            if (!sample_en) se_run = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int k_end; bit gd, ge, se_run;
        logic [31:0] lo3, hi3, w;
        logic [TMR_W-1:0] tmr1;

        exp_w[0] = '0; exp_w[1] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check({req_lo, req_hi} == '0 && !sample_en && sample_tmr == 0 && !busy && !done && !error,
              "R1 reset state", {req_lo, req_hi}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [RAIL_W-1:0] rail;
            logic ex, lvl, ok;
            int pair, pos;
            {rail, ex, lvl, ok} = VEC[v];
            status_lo = {32{lvl}}; status_hi = {32{lvl}};
            pair = int'(rail) / 32; pos = int'(rail) % 32;
            run_cmd(rail, ex, k_end, gd, ge, lo3, hi3, se_run, tmr1);
            if (ok) begin
                w = {(ex ? 2'b01 : 2'b10), 30'(1) << pos};
                // R6: done in the 4th cycle for a matching status
                check(gd && !ge && k_end == 4, "R6 completion", 64'(k_end), 64'd4);
                // R2 R4: selected word and unchanged other word
                check((pair == 0 ? lo3 : hi3) == w, "R4 request word", 64'(pair == 0 ? lo3 : hi3), 64'(w));
                check((pair == 0 ? hi3 : lo3) == exp_w[1-pair], "R2 other pair unchanged",
                      64'(pair == 0 ? hi3 : lo3), 64'(exp_w[1-pair]));
                // R5: sample window and hold count
                check(se_run && !sample_en && tmr1 == 8'd20, "R5 sample window", 64'(tmr1), 64'd20);
                exp_w[pair] = {2'b00, w[29:0]};
                // R8: code back to idle, selector kept
                check(req_lo == exp_w[0] && req_hi == exp_w[1], "R8 code returns idle",
                      {req_lo, req_hi}, {exp_w[0], exp_w[1]});
            end else begin
                // R3: rejection
                check(ge && !gd && k_end == 1, "R3 reject pulse", 64'(k_end), 64'd1);
                check(req_lo == exp_w[0] && req_hi == exp_w[1] && !sample_en, "R3 nothing touched",
                      {req_lo, req_hi}, {exp_w[0], exp_w[1]});
            end
            @(negedge clk);
            check(!done && !error, "R10 single-cycle pulse", {62'b0, done, error}, 64'h0);
        end

        // R7: timeout, leave command on rail 3 with status stuck at 1
        status_lo = '1;
        run_cmd(7'd3, 1'b1, k_end, gd, ge, lo3, hi3, se_run, tmr1);
        check(ge && !gd && k_end == 3 + TO, "R7 timeout cycle", 64'(k_end), 64'(3 + TO));
        check(!sample_en, "R5 sample closed after timeout", 64'(sample_en), 64'h0);
        exp_w[0] = {2'b00, 30'(1) << 3};
        check(req_lo == exp_w[0], "R8 code idle after timeout", 64'(req_lo), 64'(exp_w[0]));

        // R9: command while busy is dropped; enter on rail 40, status released late
        @(negedge clk);
        status_hi = '0;
        cmd_rail = 7'd40; cmd_exit = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        cmd_rail = 7'd7; cmd_exit = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(req_lo == exp_w[0] && req_hi == {2'b10, 30'(1) << 8}, "R9 busy command ignored",
              {req_lo, req_hi}, {exp_w[0], 2'b10, 30'(1) << 8});
        status_hi = '1;
        @(negedge clk);
        check(done && !error, "R6 enter completes on status 1", {62'b0, done, error}, 64'h2);
        @(negedge clk);
        check(!busy && req_lo == exp_w[0] && req_hi == {2'b00, 30'(1) << 8}, "R9 no second run",
              {req_lo, req_hi}, {exp_w[0], 2'b00, 30'(1) << 8});
        repeat (4) @(negedge clk);
        check(!busy && !done && !error, "R9 stays idle", {61'b0, busy, done, error}, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule